// File: doc/BRIEF.md
# Peripheral Register Address Sequencer

This block drives the device side of one DMA channel that talks to a small window of peripheral registers. When a start pulse arrives it captures a base pointer, a direction and a configuration word carrying a range code and a width code. From then on it emits one bus access after another. Each access carries a register address inside a fixed 64 KB peripheral window and an access size of byte, halfword or word.

Toward the device, 32-bit data words taken from the channel are split into narrow accesses. Narrow reads coming back from the device are merged into 32-bit words for the channel. The register address moves forward only once a full 32-bit word has crossed the bus, so a narrow register is hit several times in a row. The range code sets how many consecutive registers are walked before the address returns to the base.

Every edge of the block uses a valid/ready handshake. Counting the total transfer length and handling request lines are left to the surrounding channel logic.

Top module: `periph_addr_seq`

## Requirements
- R1: After reset and before any start, `bus_valid`, `rd_word_valid` and `wr_word_ready` are all low.
- R2: Every bus address has bits 31:16 equal to 0x7000 and bits 1:0 equal to zero. The first access after a start uses 0x70000000 with bits 15:2 taken from `cfg_base` bits 15:2. All other bits of `cfg_base` are ignored.
- R3: With range code 0, the register index (address bits 15:2, relative to the base) goes up by one after each completed 32-bit word and never returns to the base. It wraps only modulo the 64 KB window.
- R4: With range code 1, every access uses the base address.
- R5: With range code 2, the address alternates word by word between the base and the base plus 4.
- R6: With a range code c from 3 to 7, the address returns to the base after 2^(c-1) words.
- R7: The range code is `cfg_incr` bits 18:16 and the width code is `cfg_incr` bits 30:28. Other bits are ignored. Width code 0 gives `bus_size` 0 (byte) with four accesses per word. Width code 1 gives `bus_size` 1 (halfword) with two accesses per word. Codes 2 to 7 give `bus_size` 2 (word) with one access per word.
- R8: In write direction (`start_dir` = 1), each word is sent little-endian, lowest lane first. `bus_wdata` carries the lane in its low bits and the unused upper bits are zero.
- R9: In read direction (`start_dir` = 0), the low bits of `bus_rdata` from each accepted access are placed little-endian, with the first access in the lowest lane. The completed word is offered on `rd_word`.
- R10: While `bus_valid` is high and `bus_ready` is low, the next cycle keeps `bus_valid` high and holds `bus_addr`, `bus_size` and `bus_wdata` unchanged.
- R11: A start reloads the base and clears the register index, the lane phase and any half-built or buffered word. The first access afterwards uses the new base.
- R12: In read direction, no bus access is offered while a completed word is waiting on `rd_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that loads the configuration and (re)starts sequencing |
| start_dir | input | 1 | 1 = channel to device (write), 0 = device to channel (read) |
| cfg_base | input | 32 | Programmed base pointer |
| cfg_incr | input | 32 | Configuration word holding the range and width codes |
| wr_word_valid | input | 1 | Channel offers a 32-bit word to send |
| wr_word_ready | output | 1 | Sequencer takes the offered word |
| wr_word | input | 32 | Word to send |
| rd_word_valid | output | 1 | A packed word is available |
| rd_word_ready | input | 1 | Channel takes the packed word |
| rd_word | output | 32 | Packed word |
| bus_valid | output | 1 | Access request to the device bus |
| bus_ready | input | 1 | Device bus accepts the access |
| bus_write | output | 1 | Access is a write |
| bus_addr | output | 32 | Register address |
| bus_size | output | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | output | 32 | Write lane, right-aligned |
| bus_rdata | input | 32 | Read lane, right-aligned, valid in the accepting cycle |

## Verification
A wrong register index shows up on `bus_addr` at the first access of the next word: an address that is off by 4, or a wrap that comes early or late. A lane phase that is out of step shows up at once as a wrong lane on `bus_wdata`. In read direction it instead shows up as a scrambled `rd_word` one accepted access after the word completes. Stale buffer or full-flag state after a restart appears on the first access or the first offered word that follows the start.

// File: rtl/periph_addr_seq_pkg.sv
package periph_addr_seq_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2
    } acc_size_e;

endpackage

// File: rtl/psq_cfg_decode.sv
module psq_cfg_decode
    import periph_addr_seq_pkg::*;
#(
    parameter int IDX_W = 14
) (
    input  logic [2:0]       range_code,
    input  logic [2:0]       width_code,
    output acc_size_e        size,
    output logic             wrap_en,
    output logic [IDX_W-1:0] limit
);

    always_comb begin
        case (width_code)
            3'd0:    size = ACC_BYTE;
            3'd1:    size = ACC_HALF;
            default: size = ACC_WORD;
        endcase
        wrap_en = (range_code != 3'd0);
        // number of registers in the window: 2^(code-1)
        limit   = wrap_en ? (IDX_W'(1) << (range_code - 3'd1)) : '0;
    end

endmodule

// File: rtl/psq_addr.sv
module psq_addr #(
    parameter int          IDX_W    = 14,
    parameter logic [31:0] WIN_BASE = 32'h7000_0000
) (
    input  logic [IDX_W-1:0] base_idx,
    input  logic [IDX_W-1:0] cnt,
    input  logic             wrap_en,
    input  logic [IDX_W-1:0] limit,
    output logic [31:0]      addr,
    output logic [IDX_W-1:0] cnt_next
);

    localparam int AW = IDX_W + 2;

    logic [IDX_W-1:0] reg_idx;
    logic [IDX_W-1:0] cnt_inc;

    always_comb begin
        reg_idx  = base_idx + cnt;
        addr     = {WIN_BASE[31:AW], reg_idx, 2'b00};
        cnt_inc  = cnt + IDX_W'(1);
        cnt_next = (wrap_en && (cnt_inc >= limit)) ? '0 : cnt_inc;
    end

endmodule

// File: rtl/psq_lane.sv
module psq_lane
    import periph_addr_seq_pkg::*;
(
    input  acc_size_e          size,
    input  logic [1:0]         phase,
    input  logic [WORD_W-1:0]  buf_word,
    input  logic [WORD_W-1:0]  acc_word,
    input  logic [WORD_W-1:0]  rdata,
    output logic               last,
    output logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  merged
);

    logic [4:0]        shift;
    logic [WORD_W-1:0] mask;

    always_comb begin
        case (size)
            ACC_BYTE: begin
                shift = {phase, 3'b000};
                mask  = WORD_W'(32'h0000_00FF);
                last  = (phase == 2'd3);
            end
            ACC_HALF: begin
                shift = {phase[0], 4'b0000};
                mask  = WORD_W'(32'h0000_FFFF);
                last  = phase[0];
            end
            default: begin
                shift = 5'd0;
                mask  = '1;
                last  = 1'b1;
            end
        endcase
        wdata  = (buf_word >> shift) & mask;
        merged = (acc_word & ~(mask << shift)) | ((rdata & mask) << shift);
    end

endmodule

// File: rtl/periph_addr_seq.sv
module periph_addr_seq
    import periph_addr_seq_pkg::*;
#(
    parameter int          WIN_AW    = 16,
    parameter logic [31:0] WIN_BASE  = 32'h7000_0000,
    parameter int          RANGE_LSB = 16,
    parameter int          WIDTH_LSB = 28
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        start_dir,
    input  logic [31:0] cfg_base,
    input  logic [31:0] cfg_incr,
    input  logic        wr_word_valid,
    output logic        wr_word_ready,
    input  logic [31:0] wr_word,
    output logic        rd_word_valid,
    input  logic        rd_word_ready,
    output logic [31:0] rd_word,
    output logic        bus_valid,
    input  logic        bus_ready,
    output logic        bus_write,
    output logic [31:0] bus_addr,
    output logic [1:0]  bus_size,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata
);

    localparam int IDX_W = WIN_AW - 2;

    typedef struct packed {
        logic              active;
        logic              dir;
        logic [2:0]        rcode;
        logic [2:0]        wcode;
        logic [IDX_W-1:0]  base_idx;
        logic [IDX_W-1:0]  cnt;
        logic [1:0]        phase;
        logic              buf_full;
        logic [WORD_W-1:0] buf_word;
        logic [WORD_W-1:0] acc;
        logic              out_full;
        logic [WORD_W-1:0] out_word;
    } seq_state_t;

    seq_state_t s_q, s_d;

    acc_size_e         size;
    logic              wrap_en;
    logic [IDX_W-1:0]  limit;
    logic [IDX_W-1:0]  cnt_next;
    logic [31:0]       addr;
    logic              last;
    logic [WORD_W-1:0] lane_wdata;
    logic [WORD_W-1:0] merged;
    logic              acc_fire;
    logic              unused_cfg;

    assign unused_cfg = ^{cfg_base, cfg_incr};

    psq_cfg_decode #(.IDX_W(IDX_W)) u_dec (
        .range_code (s_q.rcode),
        .width_code (s_q.wcode),
        .size       (size),
        .wrap_en    (wrap_en),
        .limit      (limit)
    );

    psq_addr #(.IDX_W(IDX_W), .WIN_BASE(WIN_BASE)) u_addr (
        .base_idx (s_q.base_idx),
        .cnt      (s_q.cnt),
        .wrap_en  (wrap_en),
        .limit    (limit),
        .addr     (addr),
        .cnt_next (cnt_next)
    );

    psq_lane u_lane (
        .size     (size),
        .phase    (s_q.phase),
        .buf_word (s_q.buf_word),
        .acc_word (s_q.acc),
        .rdata    (bus_rdata),
        .last     (last),
        .wdata    (lane_wdata),
        .merged   (merged)
    );

    always_comb begin
        s_d = s_q;

        bus_valid     = s_q.active && (s_q.dir ? s_q.buf_full : !s_q.out_full);
        bus_write     = s_q.dir;
        bus_addr      = addr;
        bus_size      = size;
        bus_wdata     = s_q.dir ? lane_wdata : '0;
        wr_word_ready = s_q.active && s_q.dir && !s_q.buf_full && !start;
        rd_word_valid = s_q.out_full;
        rd_word       = s_q.out_word;
        acc_fire      = bus_valid && bus_ready;

        if (rd_word_valid && rd_word_ready) begin
            s_d.out_full = 1'b0;
        end
        if (wr_word_valid && wr_word_ready) begin
            s_d.buf_full = 1'b1;
            s_d.buf_word = wr_word;
        end
        if (acc_fire) begin
            if (last) begin
                s_d.phase = 2'd0;
                s_d.cnt   = cnt_next;
                if (s_q.dir) begin
                    s_d.buf_full = 1'b0;
                end else begin
                    s_d.out_full = 1'b1;
                    s_d.out_word = merged;
                    s_d.acc      = '0;
                end
            end else begin
                s_d.phase = s_q.phase + 2'd1;
                if (!s_q.dir) begin
                    s_d.acc = merged;
                end
            end
        end

        // a start overrides every other update in the same cycle
        if (start) begin
            s_d.active   = 1'b1;
            s_d.dir      = start_dir;
            s_d.rcode    = cfg_incr[RANGE_LSB +: 3];
            s_d.wcode    = cfg_incr[WIDTH_LSB +: 3];
            s_d.base_idx = cfg_base[2 +: IDX_W];
            s_d.cnt      = '0;
            s_d.phase    = 2'd0;
            s_d.buf_full = 1'b0;
            s_d.out_full = 1'b0;
            s_d.acc      = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

module periph_addr_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        bus_valid,
    input logic        bus_ready,
    input logic        bus_write,
    input logic [31:0] bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic        rd_word_valid,
    input logic        rd_word_ready,
    input logic        wr_word_ready
);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!bus_valid && !rd_word_valid && !wr_word_ready));

    // R2
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_addr[31:16] == 16'h7000 && bus_addr[1:0] == 2'b00));

    // R7
    size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_size != 2'd3));

    // R8
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size == 2'd0) |-> (bus_wdata[31:8] == 24'h0));

    // R10
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready && !start) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_size) && $stable(bus_wdata)));

    // R12
    no_access_while_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word_valid && !rd_word_ready && !bus_write && !start) |=> !bus_valid);

endmodule

bind periph_addr_seq periph_addr_seq_chk u_chk (.*);

// File: tb/periph_addr_seq_test.sv
module periph_addr_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_dir = 1'b0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_incr = '0;
    logic        wr_word_valid = 1'b0;
    logic        wr_word_ready;
    logic [31:0] wr_word = '0;
    logic        rd_word_valid;
    logic        rd_word_ready = 1'b0;
    logic [31:0] rd_word;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    bit          m_active = 1'b0;
    bit          m_dir;
    int          m_rcode, m_wcode;
    logic [13:0] m_base, m_cnt;
    int          m_phase;
    logic [31:0] m_acc;
    logic [31:0] wq[$];
    logic [31:0] rq[$];
    bit          first_after_start;
    bit          hold_pend;
    logic [31:0] hold_addr, hold_wdata;
    logic [1:0]  hold_size;

    periph_addr_seq uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int n_acc(input int w);
        return (w == 0) ? 4 : (w == 1) ? 2 : 1;
    endfunction

    function automatic string range_tag(input int r);
        if (r == 0) return "R3";
        if (r == 1) return "R4";
        if (r == 2) return "R5";
        return "R6";
    endfunction

    function automatic logic [31:0] exp_addr();
        logic [13:0] idx;
        idx = m_base + m_cnt;
        return {16'h7000, idx, 2'b00};
    endfunction

    function automatic logic [31:0] mk_incr(input int r, input int w);
        logic [31:0] junk;
        junk = $urandom & ~((32'h7 << 16) | (32'h7 << 28));
        return junk | (32'(r) << 16) | (32'(w) << 28);
    endfunction

    task automatic do_start(input bit dir, input logic [31:0] base, input logic [31:0] incr);
        @(negedge clk);
        start = 1'b1; start_dir = dir; cfg_base = base; cfg_incr = incr;
        bus_ready = 1'b0; wr_word_valid = 1'b0; rd_word_ready = 1'b0;
        @(posedge clk);
        #1;
        start = 1'b0;
        m_active = 1'b1; m_dir = dir;
        m_rcode = int'(incr[18:16]); m_wcode = int'(incr[30:28]);
        m_base = base[15:2]; m_cnt = '0; m_phase = 0; m_acc = '0;
        wq.delete(); rq.delete();
        first_after_start = 1'b1; hold_pend = 1'b0;
    endtask

    task automatic model_access();
        int          bits;
        int          sh;
        logic [31:0] mask, e;
        int          n;
        n    = n_acc(m_wcode);
        bits = 32 / n;
        sh   = m_phase * bits;
        mask = (bits == 32) ? 32'hFFFF_FFFF : ((32'h1 << bits) - 1);
        e = exp_addr();
        chk(bus_addr == e, range_tag(m_rcode), bus_addr, e);
        chk(bus_addr[31:16] == 16'h7000 && bus_addr[1:0] == 2'b00, "R2", bus_addr, e);
        if (first_after_start) begin
            chk(bus_addr == {16'h7000, m_base, 2'b00}, "R11", bus_addr, {16'h7000, m_base, 2'b00});
            first_after_start = 1'b0;
        end
        chk(bus_size == 2'(n == 4 ? 0 : n == 2 ? 1 : 2), "R7", 32'(bus_size), 32'(n == 4 ? 0 : n == 2 ? 1 : 2));
        if (m_dir) begin
            if (wq.size() == 0) begin
                chk(1'b0, "R8", bus_wdata, 32'hx);
            end else begin
                e = (wq[0] >> sh) & mask;
                chk(bus_wdata == e, "R8", bus_wdata, e);
            end
        end else begin
            m_acc = (m_acc & ~(mask << sh)) | ((bus_rdata & mask) << sh);
        end
        m_phase++;
        if (m_phase == n) begin
            m_phase = 0;
            if (m_rcode == 0) begin
                m_cnt = m_cnt + 14'd1;
            end else if (int'(m_cnt) + 1 >= (1 << (m_rcode - 1))) begin
                m_cnt = '0;
            end else begin
                m_cnt = m_cnt + 14'd1;
            end
            if (m_dir) begin
                if (wq.size() != 0) void'(wq.pop_front());
            end else begin
                rq.push_back(m_acc);
                m_acc = '0;
            end
        end
    endtask

    task automatic step(input int p_ready, input int p_wv, input int p_rr);
        logic [31:0] e;
        @(negedge clk);
        bus_ready     = ($urandom % 100) < p_ready;
        wr_word_valid = ($urandom % 100) < p_wv;
        wr_word       = $urandom;
        rd_word_ready = ($urandom % 100) < p_rr;
        bus_rdata     = $urandom;
        #1;
        if (hold_pend) begin
            chk(bus_valid && bus_addr == hold_addr && bus_size == hold_size && bus_wdata == hold_wdata,
                "R10", bus_addr, hold_addr);
        end
        hold_pend  = bus_valid && !bus_ready;
        hold_addr  = bus_addr;
        hold_size  = bus_size;
        hold_wdata = bus_wdata;
        if (m_active && !m_dir && rd_word_valid) begin
            chk(!bus_valid, "R12", 32'(bus_valid), 32'd0);
        end
        if (bus_valid && bus_ready) model_access();
        if (wr_word_valid && wr_word_ready) wq.push_back(wr_word);
        if (rd_word_valid && rd_word_ready) begin
            if (rq.size() == 0) begin
                chk(1'b0, "R9", rd_word, 32'hx);
            end else begin
                e = rq.pop_front();
                chk(rd_word == e, "R9", rd_word, e);
            end
        end
    endtask

    task automatic run(input int cycles, input int p_ready, input int p_wv, input int p_rr);
        for (int i = 0; i < cycles; i++) step(p_ready, p_wv, p_rr);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs after reset
        chk(!bus_valid, "R1", 32'(bus_valid), 32'd0);
        chk(!rd_word_valid, "R1", 32'(rd_word_valid), 32'd0);
        chk(!wr_word_ready, "R1", 32'(wr_word_ready), 32'd0);

        // R2: base with garbage outside bits 15:2, byte writes, alternating range
        do_start(1'b1, 32'hDEAD_BEEF, mk_incr(2, 0));
        run(120, 70, 80, 80);

        // R4 fixed register, halfword reads
        do_start(1'b0, 32'h1234_0010, mk_incr(1, 1));
        run(120, 70, 80, 70);

        // R3 unlimited, word writes, crossing the top of the window
        do_start(1'b1, 32'h7000_FFF8, mk_incr(0, 2));
        run(80, 100, 100, 100);

        // R6 range 7 with width code 7, reads
        do_start(1'b0, 32'h0000_0100, mk_incr(7, 7));
        run(400, 90, 100, 100);

        // R12 read words left unconsumed for a while
        do_start(1'b0, 32'h0000_0040, mk_incr(3, 0));
        run(60, 100, 0, 0);
        run(100, 80, 0, 60);

        // R11 restart in the middle of a byte word, write then read
        do_start(1'b1, 32'h0000_0200, mk_incr(4, 0));
        run(7, 100, 100, 100);
        do_start(1'b1, 32'h0000_0300, mk_incr(5, 1));
        run(50, 80, 80, 80);
        do_start(1'b0, 32'h0000_0400, mk_incr(3, 0));
        run(3, 100, 100, 0);
        do_start(1'b0, 32'h0000_0500, mk_incr(2, 1));
        run(60, 80, 80, 80);

        // R10 long stall then drain
        do_start(1'b1, 32'h0000_0600, mk_incr(3, 1));
        run(15, 0, 100, 100);
        run(40, 100, 100, 100);

        // random mix
        for (int t = 0; t < 40; t++) begin
            do_start(1'($urandom), $urandom, mk_incr(int'($urandom % 8), int'($urandom % 8)));
            run(250, 20 + int'($urandom % 80), 20 + int'($urandom % 80), 20 + int'($urandom % 80));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule